// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit sits beside instruction decode and works out where the program counter goes after a control-transfer instruction. It takes the current 64-bit PC, the 32-bit instruction word and the values already read for the two source registers. It returns four things:

- the next PC;
- whether the transfer was taken;
- the return-address value, with a write enable for it;
- a flag that marks any instruction outside the branch and jump groups.

Fetch and the register file stay outside. The caller writes the link value into the register named by instruction bits 25:21 when the enable is high.

There are three instruction groups. Branch-format instructions carry a signed word displacement measured from the incremented PC. Eight conditional codes test the first source register against zero, or test its lowest bit. The jump group takes its target from the second source register with the lowest bit forced to zero. Register index 31 is the hard-wired zero register, so it never receives a link write.

Top module: `brj_next_pc`

## Requirements
- R1: For any major opcode (bits 31:26) other than 0x1A, 0x30, 0x34 and 0x38..0x3F, the unit outputs `next_pc_o` = PC+4, `taken_o`=0, `link_we_o`=0 and `not_ctl_o`=1. For all control transfers, `not_ctl_o`=0.
- R2: The branch target is PC+4 plus the sign-extended bits 20:0 multiplied by four. Bit 20 is the sign, so displacements range from -1048576 to +1048575 words.
- R3: Opcodes 0x30 and 0x34 are always taken and go to the branch target. They assert `link_we_o` exactly when the Ra field (bits 25:21) is not 31.
- R4: For opcodes 0x38..0x3F, the low three opcode bits select a test of the Ra value. The tests are: 0 low bit clear, 1 equal to zero, 2 negative, 3 less than or equal to zero, 4 low bit set, 5 non-zero, 6 greater than or equal to zero, 7 greater than zero. All comparisons are signed, in two's complement. A passing test is taken and goes to the branch target.
- R5: A conditional branch whose test fails outputs PC+4 with `taken_o`=0.
- R6: Opcode 0x1A is always taken. It goes to the Rb value with bit 0 cleared and asserts `link_we_o` exactly when the Ra field is not 31.
- R7: A conditional branch never asserts `link_we_o`, whether taken or not.
- R8: `link_val_o` always equals PC+4, and all PC arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc_i | input | 64 | Address of the current instruction |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Value of the register named by bits 25:21 |
| rb_val_i | input | 64 | Value of the register named by bits 20:16 |
| next_pc_o | output | 64 | Address of the next instruction |
| taken_o | output | 1 | Control transfer was taken |
| link_val_o | output | 64 | Return address (PC+4) |
| link_we_o | output | 1 | Write `link_val_o` to the Ra register |
| not_ctl_o | output | 1 | Instruction is not a branch or jump |

## Verification
The bench builds two copies of the unit with the default widths. One uses `COND_STYLE` 0, where each of the eight tests is decoded on its own. The other uses `COND_STYLE` 1, where four base tests are inverted by opcode bit 2. Each copy is compared against the same reference on every stimulus. This exposes a fault that shows up in only one of the two condition decoders. Each of the eight tests is driven with zero, one, minus one, the most negative value and an even positive value. The two extreme displacements and PC wraparound are also exercised.

// File: rtl/brj_pkg.sv
package brj_pkg;

  localparam int XLEN       = 64;
  localparam int ILEN       = 32;
  localparam int OPC_W      = 6;
  localparam int REG_W      = 5;
  localparam int DISP_W     = 21;
  localparam int INSN_BYTES = 4;

  localparam logic [5:0] OPC_JUMP   = 6'h1A;
  localparam logic [5:0] OPC_BR     = 6'h30;
  localparam logic [5:0] OPC_BSR    = 6'h34;
  localparam logic [2:0] COND_GROUP = 3'b111;

  typedef enum logic [1:0] {
    CLS_OTHER  = 2'd0,
    CLS_UNCOND = 2'd1,
    CLS_COND   = 2'd2,
    CLS_JUMP   = 2'd3
  } xfer_cls_e;

  // encoding equals the low three opcode bits of the conditional group
  typedef enum logic [2:0] {
    TST_LOW_CLR = 3'd0,
    TST_ZERO    = 3'd1,
    TST_NEG     = 3'd2,
    TST_NONPOS  = 3'd3,
    TST_LOW_SET = 3'd4,
    TST_NZERO   = 3'd5,
    TST_NONNEG  = 3'd6,
    TST_POS     = 3'd7
  } tst_e;

endpackage

// File: rtl/brj_decode.sv
module brj_decode
  import brj_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int OW = OPC_W,
  parameter int RW = REG_W,
  parameter int DW = DISP_W
) (
  input  logic [IW-1:0] insn_i,
  output xfer_cls_e     cls_o,
  output tst_e          tst_o,
  output logic          ra_zero_o,
  output logic [DW-1:0] disp_o
);

  localparam int RA_LSB = IW - OW - RW;

  logic [OW-1:0] opc;
  logic [RW-1:0] ra_idx;
  logic [DW-1:0] disp_raw;

  assign opc      = insn_i[IW-1 -: OW];
  assign ra_idx   = insn_i[RA_LSB +: RW];
  assign disp_raw = insn_i[DW-1:0];

  // register index with all ones is the hard-wired zero register
  function automatic logic is_zero_reg(input logic [RW-1:0] idx);
    return &idx;
  endfunction

  function automatic xfer_cls_e classify(input logic [OW-1:0] op);
    xfer_cls_e c;
    if (op == OW'(OPC_JUMP))                          c = CLS_JUMP;
    else if (op == OW'(OPC_BR) || op == OW'(OPC_BSR)) c = CLS_UNCOND;
    else if (op[OW-1 -: 3] == COND_GROUP)             c = CLS_COND;
    else                                              c = CLS_OTHER;
    return c;
  endfunction

  assign cls_o     = classify(opc);
  assign tst_o     = tst_e'(opc[2:0]);
  assign ra_zero_o = is_zero_reg(ra_idx);
  assign disp_o    = disp_raw;

endmodule

// File: rtl/brj_cond_eval.sv
module brj_cond_eval
  import brj_pkg::*;
#(
  parameter int XW         = XLEN,
  parameter int COND_STYLE = 0
) (
  input  logic [XW-1:0] val_i,
  input  tst_e          tst_i,
  output logic          hit_o
);

  logic is_zero, is_neg, low_bit;

  assign is_zero = (val_i == '0);
  assign is_neg  = val_i[XW-1];
  assign low_bit = val_i[0];

  if (COND_STYLE == 0) begin : g_full
    // one decoder arm per test
    always_comb begin
      unique case (tst_i)
        TST_LOW_CLR: hit_o = !low_bit;
        TST_ZERO:    hit_o = is_zero;
        TST_NEG:     hit_o = is_neg;
        TST_NONPOS:  hit_o = is_neg || is_zero;
        TST_LOW_SET: hit_o = low_bit;
        TST_NZERO:   hit_o = !is_zero;
        TST_NONNEG:  hit_o = !is_neg;
        TST_POS:     hit_o = !is_neg && !is_zero;
        default:     hit_o = 1'b0;
      endcase
    end
  end else begin : g_fold
    // four base tests, bit 2 of the code inverts the sense
    logic base;
    logic [1:0] sel;
    logic inv;
    assign sel = tst_i[1:0];
    assign inv = tst_i[2];
    always_comb begin
      unique case (sel)
        2'd0: base = !low_bit;
        2'd1: base = is_zero;
        2'd2: base = is_neg;
        default: base = is_neg || is_zero;
      endcase
    end
    assign hit_o = base ^ inv;
  end

endmodule

// File: rtl/brj_target.sv
module brj_target
  import brj_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int DW = DISP_W
) (
  input  logic [XW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  input  logic [XW-1:0] rb_val_i,
  output logic [XW-1:0] seq_pc_o,
  output logic [XW-1:0] br_tgt_o,
  output logic [XW-1:0] jmp_tgt_o
);

  localparam int EXT_W = XW - DW - 2;

  function automatic logic [XW-1:0] step_pc(input logic [XW-1:0] pc);
    return pc + XW'(INSN_BYTES);
  endfunction

  function automatic logic [XW-1:0] word_offset(input logic [DW-1:0] d);
    return {{EXT_W{d[DW-1]}}, d, 2'b00};
  endfunction

  function automatic logic [XW-1:0] align_jump(input logic [XW-1:0] v);
    return {v[XW-1:1], 1'b0};
  endfunction

  assign seq_pc_o  = step_pc(pc_i);
  assign br_tgt_o  = seq_pc_o + word_offset(disp_i);
  assign jmp_tgt_o = align_jump(rb_val_i);

endmodule

// File: rtl/brj_next_pc.sv
module brj_next_pc
  import brj_pkg::*;
#(
  parameter int XW         = XLEN,
  parameter int IW         = ILEN,
  parameter int OW         = OPC_W,
  parameter int RW         = REG_W,
  parameter int DW         = DISP_W,
  parameter int COND_STYLE = 0
) (
  input  logic [XW-1:0] cur_pc_i,
  input  logic [IW-1:0] insn_i,
  input  logic [XW-1:0] ra_val_i,
  input  logic [XW-1:0] rb_val_i,
  output logic [XW-1:0] next_pc_o,
  output logic          taken_o,
  output logic [XW-1:0] link_val_o,
  output logic          link_we_o,
  output logic          not_ctl_o
);

  xfer_cls_e     cls;
  tst_e          tst;
  logic [DW-1:0] disp;
  logic [XW-1:0] seq_pc, br_tgt, jmp_tgt;

  // named events for the checker
  logic is_uncond_w, is_cond_w, is_jump_w, is_other_w;
  logic cond_hit_w, ra_zero_w;

  brj_decode #(.IW(IW), .OW(OW), .RW(RW), .DW(DW)) u_dec (
    .insn_i    (insn_i),
    .cls_o     (cls),
    .tst_o     (tst),
    .ra_zero_o (ra_zero_w),
    .disp_o    (disp)
  );

  brj_cond_eval #(.XW(XW), .COND_STYLE(COND_STYLE)) u_cond (
    .val_i (ra_val_i),
    .tst_i (tst),
    .hit_o (cond_hit_w)
  );

  brj_target #(.XW(XW), .DW(DW)) u_tgt (
    .pc_i      (cur_pc_i),
    .disp_i    (disp),
    .rb_val_i  (rb_val_i),
    .seq_pc_o  (seq_pc),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  assign is_uncond_w = (cls == CLS_UNCOND);
  assign is_cond_w   = (cls == CLS_COND);
  assign is_jump_w   = (cls == CLS_JUMP);
  assign is_other_w  = (cls == CLS_OTHER);

  always_comb begin
    next_pc_o = seq_pc;
    taken_o   = 1'b0;
    link_we_o = 1'b0;
    not_ctl_o = 1'b0;
    unique case (cls)
      CLS_UNCOND: begin
        next_pc_o = br_tgt;
        taken_o   = 1'b1;
        link_we_o = !ra_zero_w;
      end
      CLS_COND: begin
        if (cond_hit_w) begin
          next_pc_o = br_tgt;
          taken_o   = 1'b1;
        end
      end
      CLS_JUMP: begin
        next_pc_o = jmp_tgt;
        taken_o   = 1'b1;
        link_we_o = !ra_zero_w;
      end
      default: not_ctl_o = 1'b1;
    endcase
  end

  assign link_val_o = seq_pc;

endmodule

// File: rtl/brj_next_pc_chk.sv
module brj_next_pc_chk #(
  parameter int XW = 64
) (
  input logic [XW-1:0] cur_pc_i,
  input logic [XW-1:0] next_pc_o,
  input logic          taken_o,
  input logic [XW-1:0] link_val_o,
  input logic          link_we_o,
  input logic          not_ctl_o,
  input logic          is_uncond_w,
  input logic          is_cond_w,
  input logic          is_jump_w,
  input logic          is_other_w,
  input logic          cond_hit_w,
  input logic          ra_zero_w
);

  logic [XW-1:0] fall_pc;
  assign fall_pc = cur_pc_i + XW'(4);

  always_comb begin
    // R1
    idle_fallthrough_chk: assert (!not_ctl_o || (!taken_o && !link_we_o && next_pc_o == fall_pc))
      else $error("idle_fallthrough_chk");
    // R1
    class_onehot_chk: assert ($onehot({is_uncond_w, is_cond_w, is_jump_w, is_other_w}))
      else $error("class_onehot_chk");
    // R3
    uncond_taken_chk: assert (!is_uncond_w || (taken_o && !not_ctl_o))
      else $error("uncond_taken_chk");
    // R4
    cond_follow_chk: assert (!is_cond_w || (taken_o == cond_hit_w))
      else $error("cond_follow_chk");
    // R5
    nottaken_seq_chk: assert (taken_o || next_pc_o == fall_pc)
      else $error("nottaken_seq_chk");
    // R6
    jump_align_chk: assert (!is_jump_w || (taken_o && !next_pc_o[0]))
      else $error("jump_align_chk");
    // R7
    cond_nolink_chk: assert (!is_cond_w || !link_we_o)
      else $error("cond_nolink_chk");
    // R3 R6
    zero_reg_nolink_chk: assert (!ra_zero_w || !link_we_o)
      else $error("zero_reg_nolink_chk");
    // R8
    link_value_chk: assert (link_val_o == fall_pc)
      else $error("link_value_chk");
  end

endmodule

bind brj_next_pc brj_next_pc_chk #(.XW(XW)) u_chk (
  .cur_pc_i    (cur_pc_i),
  .next_pc_o   (next_pc_o),
  .taken_o     (taken_o),
  .link_val_o  (link_val_o),
  .link_we_o   (link_we_o),
  .not_ctl_o   (not_ctl_o),
  .is_uncond_w (is_uncond_w),
  .is_cond_w   (is_cond_w),
  .is_jump_w   (is_jump_w),
  .is_other_w  (is_other_w),
  .cond_hit_w  (cond_hit_w),
  .ra_zero_w   (ra_zero_w)
);

// File: tb/brj_next_pc_test.sv
`timescale 1ns/1ps
module brj_next_pc_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] pc, ra_v, rb_v;
  logic [31:0] insn;

  logic [63:0] a_next, a_link, b_next, b_link;
  logic a_tk, a_we, a_nc, b_tk, b_we, b_nc;

  int checks = 0;
  int fails  = 0;

  brj_next_pc #(.COND_STYLE(0)) uut (
    .cur_pc_i(pc), .insn_i(insn), .ra_val_i(ra_v), .rb_val_i(rb_v),
    .next_pc_o(a_next), .taken_o(a_tk), .link_val_o(a_link),
    .link_we_o(a_we), .not_ctl_o(a_nc)
  );

  brj_next_pc #(.COND_STYLE(1)) uut_fold (
    .cur_pc_i(pc), .insn_i(insn), .ra_val_i(ra_v), .rb_val_i(rb_v),
    .next_pc_o(b_next), .taken_o(b_tk), .link_val_o(b_link),
    .link_we_o(b_we), .not_ctl_o(b_nc)
  );

  // reference restated from the requirements
  function automatic void model(input logic [63:0] p, input logic [31:0] i,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] nx, output logic tk,
                                output logic we, output logic nc);
    logic [63:0] inc;
    logic [63:0] off;
    logic signed [63:0] sa;
    logic r31;
    logic hit;
    inc = p + 64'd4;
    off = {{41{i[20]}}, i[20:0], 2'b00};
    sa  = a;
    r31 = (i[25:21] == 5'd31);
    nx = inc; tk = 1'b0; we = 1'b0; nc = 1'b0; hit = 1'b0;
    case (i[31:26])
      6'h30, 6'h34: begin tk = 1'b1; nx = inc + off; we = !r31; end
      6'h1A:        begin tk = 1'b1; nx = b & ~64'd1; we = !r31; end
      6'h38: hit = (a[0] == 1'b0);
      6'h39: hit = (a == 64'd0);
      6'h3A: hit = (sa < 0);
      6'h3B: hit = (sa <= 0);
      6'h3C: hit = (a[0] == 1'b1);
      6'h3D: hit = (a != 64'd0);
      6'h3E: hit = (sa >= 0);
      6'h3F: hit = (sa > 0);
      default: nc = 1'b1;
    endcase
    if (i[31:29] == 3'b111 && hit) begin tk = 1'b1; nx = inc + off; end
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (insn %h pc %h ra %h)", req, what, act, exp, insn, pc, ra_v);
    end
  endtask

  // drive after a rising edge, compare at the following falling edge
  task automatic apply(input string req, input logic [63:0] p, input logic [31:0] i,
                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] e_nx;
    logic e_tk, e_we, e_nc;
    @(posedge clk);
    pc = p; insn = i; ra_v = a; rb_v = b;
    model(p, i, a, b, e_nx, e_tk, e_we, e_nc);
    @(negedge clk);
    cmp(req, "next_pc",  a_next, e_nx);
    cmp(req, "taken",    {63'd0, a_tk}, {63'd0, e_tk});
    cmp(req, "link_we",  {63'd0, a_we}, {63'd0, e_we});
    cmp(req, "not_ctl",  {63'd0, a_nc}, {63'd0, e_nc});
    cmp(req, "link_val", a_link, p + 64'd4);
    cmp(req, "fold next_pc", b_next, e_nx);
    cmp(req, "fold taken",   {63'd0, b_tk}, {63'd0, e_tk});
    cmp(req, "fold link_we", {63'd0, b_we}, {63'd0, e_we});
    cmp(req, "fold not_ctl", {63'd0, b_nc}, {63'd0, e_nc});
  endtask

  function automatic logic [31:0] br_word(input logic [5:0] op, input logic [4:0] ra, input logic [20:0] d);
    return {op, ra, d};
  endfunction

  // R1: reset-time instruction and other opcodes fall through
  task automatic t_other();
    apply("R1", 64'h0000_0000_0001_0000, 32'h0000_0000, 64'd5, 64'd9);
    apply("R1", 64'h0000_0000_0001_0004, {6'h10, 26'h0123456}, 64'd0, 64'd0);
    apply("R1", 64'h0000_0000_0002_0000, {6'h1B, 26'h3FFFFFF}, 64'd1, 64'd3);
    apply("R1", 64'h1234_0000_0000_0000, {6'h2F, 26'h0000001}, 64'd0, 64'd0);
    apply("R1", 64'h0000_0000_0000_0100, {6'h37, 26'h0000010}, 64'd0, 64'd0);
  endtask

  // R2 R3: unconditional with both link cases and extreme displacements
  task automatic t_uncond();
    apply("R3", 64'h0000_0000_0000_1000, br_word(6'h30, 5'd26, 21'd16), 64'd0, 64'd0);
    apply("R3", 64'h0000_0000_0000_1000, br_word(6'h34, 5'd31, 21'h1FFFFE), 64'd0, 64'd0);
    apply("R3", 64'h0000_0000_0000_2000, br_word(6'h34, 5'd0, 21'd3), 64'd0, 64'd0);
    apply("R2", 64'h0000_0000_8000_0000, br_word(6'h30, 5'd1, 21'h0FFFFF), 64'd0, 64'd0);
    apply("R2", 64'h0000_0000_8000_0000, br_word(6'h30, 5'd1, 21'h100000), 64'd0, 64'd0);
  endtask

  // R4 R5 R7: every conditional code against several Ra values
  task automatic t_cond();
    logic [63:0] vals [5];
    vals[0] = 64'd0; vals[1] = 64'd1; vals[2] = '1;
    vals[3] = 64'h8000_0000_0000_0000; vals[4] = 64'd6;
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 5; v++) begin
        apply("R4", 64'h0000_0000_0040_0000, br_word(6'h38 + 6'(c), 5'd4, 21'd100), vals[v], 64'd0);
      end
    end
    apply("R5", 64'h0000_0000_0040_0000, br_word(6'h39, 5'd2, 21'd8), 64'd7, 64'd0);
    apply("R7", 64'h0000_0000_0040_0000, br_word(6'h3D, 5'd9, 21'h1FFFF0), 64'd7, 64'd0);
  endtask

  // R6: jump group
  task automatic t_jump();
    apply("R6", 64'h0000_0000_0000_3000, {6'h1A, 5'd26, 5'd27, 16'h4000}, 64'd0, 64'h0000_0000_0012_3457);
    apply("R6", 64'h0000_0000_0000_3000, {6'h1A, 5'd31, 5'd26, 16'h8000}, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R6", 64'h0000_0000_0000_3004, {6'h1A, 5'd0, 5'd3, 16'h0000}, 64'd0, 64'h0000_0000_0000_0800);
  endtask

  // R8: wraparound of the incremented PC and of the target
  task automatic t_wrap();
    apply("R8", 64'hFFFF_FFFF_FFFF_FFFC, br_word(6'h30, 5'd5, 21'd0), 64'd0, 64'd0);
    apply("R8", 64'hFFFF_FFFF_FFFF_FFF8, br_word(6'h3E, 5'd5, 21'd4), 64'd0, 64'd0);
    apply("R8", 64'h0000_0000_0000_0000, br_word(6'h30, 5'd5, 21'h1FFFFE), 64'd0, 64'd0);
  endtask

  initial begin
    pc = '0; insn = '0; ra_v = '0; rb_v = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_other();
    t_uncond();
    t_cond();
    t_jump();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule